// File: doc/BRIEF.md
# Dual-Path Clock Synthesizer Configuration Register

This block holds the settings of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test-observation select. The settings can be written two ways. A parallel path captures the feedback value and output select from dedicated input pins when the parallel strobe rises. A serial path shifts a 14-bit word, one bit per rising edge of a serial clock, and commits it to the settings when a serial commit strobe falls.

Each path is gated by the strobe level of the other path. A parallel capture happens only while the serial commit strobe is low. A serial commit happens only while the parallel strobe is high. If both commit conditions arise in the same cycle, the parallel values are taken. All strobes, the serial clock and the serial data are asynchronous to the system clock. They pass through a two-flop synchronizer before their edges are detected. Each settings update raises a one-cycle update pulse. The block also presents the decoded output divide ratio.

Top module: `synth_cfg_if`

## Requirements
- R1: The serial shifter is 14 bits wide. On each synchronized rising edge of `ser_clk_i` it moves left by one place and takes the synchronized `ser_din_i` into bit 0. Only the last 14 bits shifted in are kept.
- R2: A synchronized falling edge of `ser_commit_i`, while the synchronized `par_strobe_i` is high, loads the settings from the shifter. `tsel_o` takes bits 13:11, `osel_o` takes bits 10:9 and `loop_div_o` takes bits 8:0. The first bit shifted is therefore T[2] and the last is M[0].
- R3: A synchronized rising edge of `par_strobe_i`, while the synchronized `ser_commit_i` is low, captures `par_loop_i` into `loop_div_o` and `par_osel_i` into `osel_o`. `tsel_o` keeps its value.
- R4: A falling edge of `ser_commit_i` while `par_strobe_i` is low changes no output. A rising edge of `ser_commit_i` changes no output, and neither does a falling edge of `par_strobe_i`.
- R5: A rising edge of `par_strobe_i` while `ser_commit_i` is high changes no output.
- R6: When the parallel and serial commit conditions occur in the same cycle, the parallel pin values are taken and `tsel_o` keeps its value.
- R7: After reset, `loop_div_o` is 200, `osel_o` is 0, `tsel_o` is 0, `div_ratio_o` is 1 and `cfg_upd_o` is 0.
- R8: `cfg_upd_o` is high for exactly one cycle per settings update. It is high in the same cycle in which the new values first appear on the outputs.
- R9: `div_ratio_o` gives the output divide ratio for `osel_o`: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R10: A strobe transition that is applied between clock edges shows up on the outputs after the third rising clock edge that follows it. The outputs are unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_strobe_i | input | 1 | Parallel capture strobe, acts on its rising edge |
| par_loop_i | input | 9 | Parallel feedback divide value |
| par_osel_i | input | 2 | Parallel output divide select |
| ser_clk_i | input | 1 | Serial shift clock, acts on its rising edge |
| ser_din_i | input | 1 | Serial data bit |
| ser_commit_i | input | 1 | Serial commit strobe, acts on its falling edge |
| loop_div_o | output | 9 | Current feedback divide value |
| osel_o | output | 2 | Current output divide select |
| tsel_o | output | 3 | Current test-observation select |
| div_ratio_o | output | 4 | Decoded output divide ratio (1, 2, 4 or 8) |
| cfg_upd_o | output | 1 | One-cycle pulse on each settings update |

## Verification
A strobe change applied in the middle of a cycle passes two synchronizer flops and then the settings register. The new settings and the update pulse therefore appear after the third rising edge, and the pulse is gone after the fourth. The bench drives stimulus on falling edges and samples on falling edges. After a commit strobe change it checks that the outputs are still old two samples later, new with the pulse high at the third sample, and that the pulse is low at the fourth. Serial bits are held for three cycles on each side of a shift clock edge, so that data and clock pass the synchronizer together. Each case of an ignored strobe is checked by waiting five samples and then comparing every output with its old value.

// File: rtl/synth_cfg_pkg.sv
// Package: shared widths, reset values and the settings record for the
// synthesizer configuration block. Assumes the word layout T, N, M from
// the most significant end.
package synth_cfg_pkg;
    localparam int LOOP_W  = 9;
    localparam int OSEL_W  = 2;
    localparam int TSEL_W  = 3;
    localparam int WORD_W  = LOOP_W + OSEL_W + TSEL_W;
    localparam int RATIO_W = 1 << OSEL_W;
    localparam int SYNC_STAGES = 2;

    localparam logic [LOOP_W-1:0] LOOP_RST = LOOP_W'(200);
    localparam logic [OSEL_W-1:0] OSEL_RST = '0;
    localparam logic [TSEL_W-1:0] TSEL_RST = '0;

    // Settings record; packed order matches the serial word layout.
    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic [OSEL_W-1:0] osel;
        logic [LOOP_W-1:0] loop;
    } cfg_t;

    // Decode an output divide select into its ratio (power of two).
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [OSEL_W-1:0] sel);
        logic [RATIO_W-1:0] r;
        r = '0;
        r[sel] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cfg_sync_chain.sv
// Multi-stage level synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no coherence across bits is implied.
module cfg_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end

    // Remaining stages form the resolution chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge_det.sv
// Synchronizes one asynchronous strobe and flags one chosen edge of it.
// RISING=1 flags low-to-high, RISING=0 flags high-to-low. The edge flag
// is combinational from registers and lasts one clock cycle.
module cfg_edge_det #(
    parameter int STAGES = 2,
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic edge_o
);
    logic lvl;
    logic prev;

    cfg_sync_chain #(.W(1), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_i),
        .q_o  (lvl)
    );

    // Remember the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    if (RISING) begin : g_rise
        assign edge_o = lvl & ~prev;
    end else begin : g_fall
        assign edge_o = ~lvl & prev;
    end

    assign lvl_o = lvl;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);  // R10
endmodule

// File: rtl/cfg_shifter.sv
// Serial configuration shifter. Moves left one place per detected shift
// clock rise and takes the synchronized data bit into bit 0. Assumes the
// data bit went through the same synchronizer depth as the shift clock.
module cfg_shifter
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sclk_lvl_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sreg;

    // Shift on each detected rising shift clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       sreg <= '0;
        else if (shift_i) sreg <= {sreg[WORD_W-2:0], din_i};
    end

    assign word_o = sreg;

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> word_o == {$past(word_o[WORD_W-2:0]), $past(din_i)});  // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_o));  // R1
    AST_SHIFT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> sclk_lvl_i);  // R1
endmodule

// File: rtl/cfg_commit.sv
// Settings register with two gated load paths. The parallel path loads
// the divide value and select on a parallel strobe rise while the serial
// strobe is low. The serial path loads the whole word on a serial strobe
// fall while the parallel strobe is high. Parallel wins when both fire.
module cfg_commit
    import synth_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_rise_i,
    input  logic               par_lvl_i,
    input  logic               ser_fall_i,
    input  logic               ser_lvl_i,
    input  logic [LOOP_W-1:0]  par_loop_i,
    input  logic [OSEL_W-1:0]  par_osel_i,
    input  logic [WORD_W-1:0]  word_i,
    output cfg_t               cfg_o,
    output logic               upd_o,
    output logic [RATIO_W-1:0] ratio_o
);
    logic par_fire;
    logic ser_fire;
    cfg_t cfg_q;
    cfg_t cfg_d;

    // Each path is gated by the other path's strobe level.
    always_comb begin
        par_fire = par_rise_i & ~ser_lvl_i;
        ser_fire = ser_fall_i &  par_lvl_i;
    end

    // Next settings: the parallel path has priority over the serial path.
    always_comb begin
        cfg_d = cfg_q;
        if (par_fire) begin
            cfg_d.loop = par_loop_i;
            cfg_d.osel = par_osel_i;
        end else if (ser_fire) begin
            cfg_d = cfg_t'(word_i);
        end
    end

    // Settings register and update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{tsel: TSEL_RST, osel: OSEL_RST, loop: LOOP_RST};
            upd_o <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            upd_o <= par_fire | ser_fire;
        end
    end

    assign cfg_o   = cfg_q;
    assign ratio_o = ratio_of(cfg_q.osel);

    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        par_fire |=> cfg_o.loop == $past(par_loop_i) && cfg_o.osel == $past(par_osel_i));  // R3
    AST_PAR_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_n)
        par_fire |=> $stable(cfg_o.tsel));  // R6
    AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_fire && !par_fire) |=> cfg_o == $past(word_i));  // R2
    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_fire || ser_fire) |=> $stable(cfg_o) && !upd_o);  // R4
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_fire || ser_fire) |=> upd_o);  // R8
    AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ratio_o) == 1);  // R9
endmodule

// File: rtl/synth_cfg_if.sv
// Top of the synthesizer configuration block. Synchronizes the strobes,
// the shift clock and the serial data; detects the edge each path acts
// on; shifts the serial word; and arbitrates the two load paths into the
// settings register. Assumes the parallel pins are stable around a
// parallel strobe rise.
module synth_cfg_if
    import synth_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_strobe_i,
    input  logic [LOOP_W-1:0]  par_loop_i,
    input  logic [OSEL_W-1:0]  par_osel_i,
    input  logic               ser_clk_i,
    input  logic               ser_din_i,
    input  logic               ser_commit_i,
    output logic [LOOP_W-1:0]  loop_div_o,
    output logic [OSEL_W-1:0]  osel_o,
    output logic [TSEL_W-1:0]  tsel_o,
    output logic [RATIO_W-1:0] div_ratio_o,
    output logic               cfg_upd_o
);
    logic              par_lvl, par_rise;
    logic              ser_lvl, ser_fall;
    logic              sclk_lvl, sclk_rise;
    logic              din_sync;
    logic [WORD_W-1:0] word;
    cfg_t              cfg;

    cfg_edge_det #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_par_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(par_strobe_i),
        .lvl_o(par_lvl), .edge_o(par_rise)
    );

    cfg_edge_det #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_ser_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(ser_commit_i),
        .lvl_o(ser_lvl), .edge_o(ser_fall)
    );

    cfg_edge_det #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(ser_clk_i),
        .lvl_o(sclk_lvl), .edge_o(sclk_rise)
    );

    cfg_sync_chain #(.W(1), .STAGES(SYNC_STAGES)) u_din_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ser_din_i), .q_o(din_sync)
    );

    cfg_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(sclk_rise),
        .sclk_lvl_i(sclk_lvl), .din_i(din_sync), .word_o(word)
    );

    cfg_commit u_commit (
        .clk(clk), .rst_n(rst_n),
        .par_rise_i(par_rise), .par_lvl_i(par_lvl),
        .ser_fall_i(ser_fall), .ser_lvl_i(ser_lvl),
        .par_loop_i(par_loop_i), .par_osel_i(par_osel_i),
        .word_i(word), .cfg_o(cfg), .upd_o(cfg_upd_o), .ratio_o(div_ratio_o)
    );

    assign loop_div_o = cfg.loop;
    assign osel_o     = cfg.osel;
    assign tsel_o     = cfg.tsel;

    AST_PAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rise && ser_lvl && !ser_fall) |=> !cfg_upd_o);  // R5
    AST_BOTH_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rise && !ser_lvl && ser_fall && par_lvl) |=> loop_div_o == $past(par_loop_i));  // R6
endmodule

// File: tb/synth_cfg_if_tb_top.sv
// Directed bench for synth_cfg_if: one task per scenario. Inputs are
// driven on falling clock edges and outputs sampled on falling edges.
module synth_cfg_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_strobe = 1'b0;
    logic [8:0] par_loop = '0;
    logic [1:0] par_osel = '0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_commit = 1'b0;
    logic [8:0] loop_div;
    logic [1:0] osel;
    logic [2:0] tsel;
    logic [3:0] ratio;
    logic       upd;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int exp_m = 200;
    int exp_n = 0;
    int exp_t = 0;

    always #2.5 clk = ~clk;

    synth_cfg_if dut_i (
        .clk(clk), .rst_n(rst_n),
        .par_strobe_i(par_strobe), .par_loop_i(par_loop), .par_osel_i(par_osel),
        .ser_clk_i(ser_clk), .ser_din_i(ser_din), .ser_commit_i(ser_commit),
        .loop_div_o(loop_div), .osel_o(osel), .tsel_o(tsel),
        .div_ratio_o(ratio), .cfg_upd_o(upd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare all settings outputs against the model.
    task automatic chk_cfg(input string req);
        chk(req, "loop_div", int'(loop_div), exp_m);
        chk(req, "osel", int'(osel), exp_n);
        chk(req, "tsel", int'(tsel), exp_t);
        chk("R9", "ratio", int'(ratio), 1 << exp_n);
    endtask

    // Shift a 14-bit word, first bit = bit 13.
    task automatic shift_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) begin
            ser_din = w[i];
            nwait(3);
            ser_clk = 1'b1;
            nwait(3);
            ser_clk = 1'b0;
            nwait(3);
        end
    endtask

    // After a commit strobe change: old values at +2, new values with a pulse at +3, no pulse at +4.
    task automatic chk_latency(input string req, input int om, input int on, input int ot);
        nwait(2);
        chk("R10", "loop before 3rd edge", int'(loop_div), om);
        chk("R10", "osel before 3rd edge", int'(osel), on);
        chk("R10", "tsel before 3rd edge", int'(tsel), ot);
        chk("R8", "upd before 3rd edge", int'(upd), 0);
        nwait(1);
        chk_cfg(req);
        chk("R8", "upd at 3rd edge", int'(upd), 1);
        nwait(1);
        chk("R8", "upd one cycle", int'(upd), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        nwait(3);
        rst_n = 1'b1;
        nwait(2);
        chk_cfg("R7");
        chk("R7", "upd after reset", int'(upd), 0);
    endtask

    // Parallel load from a low strobe with the serial strobe low.
    task automatic t_parallel(input int m, input int n);
        int om = exp_m, on = exp_n, ot = exp_t;
        par_strobe = 1'b0;
        nwait(5);
        chk("R4", "loop after parallel fall", int'(loop_div), exp_m);
        par_loop = 9'(m);
        par_osel = 2'(n);
        par_strobe = 1'b1;
        exp_m = m;
        exp_n = n;
        chk_latency("R3", om, on, ot);
    endtask

    // Serial commit with the parallel strobe high.
    task automatic t_serial(input logic [13:0] w, input bit junk);
        int om = exp_m, on = exp_n, ot = exp_t;
        if (junk) shift_word(14'h3);
        shift_word(w);
        ser_commit = 1'b1;
        nwait(5);
        chk("R4", "loop after serial rise", int'(loop_div), exp_m);
        chk("R4", "tsel after serial rise", int'(tsel), exp_t);
        ser_commit = 1'b0;
        exp_t = int'(w[13:11]);
        exp_n = int'(w[10:9]);
        exp_m = int'(w[8:0]);
        chk_latency(junk ? "R1" : "R2", om, on, ot);
    endtask

    // Serial fall while the parallel strobe is low; then parallel rise while serial is high.
    task automatic t_gating;
        int om, on, ot;
        par_strobe = 1'b0;
        nwait(5);
        shift_word({3'd6, 2'd1, 9'd321});
        ser_commit = 1'b1;
        nwait(5);
        ser_commit = 1'b0;
        nwait(5);
        chk_cfg("R4");
        chk("R4", "no pulse", int'(upd), 0);
        ser_commit = 1'b1;
        nwait(5);
        par_loop = 9'd77;
        par_osel = 2'd3;
        par_strobe = 1'b1;
        nwait(5);
        chk_cfg("R5");
        chk("R5", "no pulse", int'(upd), 0);
        om = exp_m; on = exp_n; ot = exp_t;
        ser_commit = 1'b0;
        exp_t = 6; exp_n = 1; exp_m = 321;
        chk_latency("R2", om, on, ot);
    endtask

    // Both commit conditions land in the same cycle.
    task automatic t_both;
        int om, on, ot;
        par_strobe = 1'b0;
        nwait(5);
        ser_commit = 1'b1;
        nwait(5);
        shift_word({3'd2, 2'd0, 9'd100});
        par_loop = 9'd450;
        par_osel = 2'd2;
        om = exp_m; on = exp_n; ot = exp_t;
        par_strobe = 1'b1;
        ser_commit = 1'b0;
        exp_m = 450; exp_n = 2;
        chk_latency("R6", om, on, ot);
        nwait(3);
        chk_cfg("R6");
    endtask

    initial begin
        t_reset();
        t_parallel(473, 1);
        t_serial({3'd5, 2'd3, 9'd202}, 1'b0);
        t_serial({3'd1, 2'd2, 9'd475}, 1'b1);
        t_gating();
        t_both();
        for (int n = 0; n < 4; n++) t_parallel(200 + n, n);
        t_parallel(511, 0);
        t_parallel(0, 3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule